// File: doc/BRIEF.md
# Multi-Channel Gamma Look-Up Table

This block holds the gamma correction tables of three display channels in one flat byte-wide memory and applies them to a stream of 24-bit pixels. Each channel owns three consecutive sub-tables of 256 entries: red first, then green, then blue. Channel c therefore starts at entry c × 768.

Software fills the memory through a two-register write port. A write to the address register sets the load pointer and an autoincrement flag. Each write to the data register stores one 8-bit entry at the pointer. When the flag is set, the pointer then advances by one and wraps at the end of the memory. A typical load writes the channel base with the flag set, followed by 768 data writes.

On the pixel side, a valid pixel is tagged with its channel. If gamma is enabled for that channel, each colour component is replaced by the entry it indexes in that channel's matching sub-table. If gamma is disabled, the pixel passes through unchanged. The result is registered and appears one cycle later. When the per-channel enables all drop to zero together, the memory is wiped, and software must reload it before enabling gamma again.

Top module: `gamma_lut_bank`

## Requirements
- R1: After reset, out_valid and out_rgb are 0, the load pointer is 0 with autoincrement off, and every table entry is 0.
- R2: The entry used for channel c, component k (red k=0, green k=1, blue k=2) and component value v is at memory index c×768 + k×256 + v.
- R3: A data-register write (wr_sel=1) stores wr_data[7:0] at the pointer. If autoincrement is on, the pointer then advances by one.
- R4: With autoincrement off, the pointer holds after a data write, so repeated data writes overwrite the same entry.
- R5: With autoincrement on, a data write at index 2303 moves the pointer to 0.
- R6: An address-register write (wr_sel=0) loads the pointer from wr_data[11:0] and the autoincrement flag from wr_data[31]. A pointer value above 2303 is taken as 0.
- R7: The output is registered one cycle after the input. For a valid pixel on a channel whose gamma_en bit is 1, out_rgb is {LUT(R), LUT(G), LUT(B)}, where R is pix_rgb[23:16], G is pix_rgb[15:8] and B is pix_rgb[7:0]. out_valid is 1 in that cycle.
- R8: For a valid pixel whose channel has gamma_en clear, or whose pix_ch is 3, out_rgb equals pix_rgb one cycle later.
- R9: At the first clock edge where gamma_en is sampled all-zero after having been non-zero, every entry becomes 0. A data write sampled at that same edge is not stored.
- R10: In a cycle after pix_valid was low, out_valid is 0 and out_rgb keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 address register, 1 data register |
| wr_data | input | 32 | Register write data |
| gamma_en | input | 3 | Per-channel gamma enable |
| pix_valid | input | 1 | Input pixel valid |
| pix_ch | input | 2 | Channel of the input pixel |
| pix_rgb | input | 24 | Input pixel, R in the top byte |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Corrected or passed-through pixel |

## Verification
The bench loads all three channels and then sends pixels on random channels under mixed enable patterns. It compares every output against a byte model of the memory. Several corner cases are aimed at directly:

- The pointer wrapping from the last entry to 0. A design that runs past the end would corrupt nothing visible and lose the write.
- An out-of-range pointer write, which must land at entry 0.
- Data writes with autoincrement off. A design that always advances would spread the values over several entries instead of overwriting one.
- Channel 3 and per-channel bypass. A wrong channel decode would substitute table values into pixels that must pass unchanged.
- The wipe on all-off. A design that misses it would keep returning stale table values once gamma is re-enabled without a reload.

// File: rtl/gamlut_pkg.sv
package gamlut_pkg;

   // colour components per pixel, in table order
   localparam int unsigned COMP_N = 3;

   typedef enum logic [1:0] {
      COMP_RED   = 2'd0,
      COMP_GREEN = 2'd1,
      COMP_BLUE  = 2'd2
   } comp_e;

   // register select values on the write port
   localparam logic SEL_ADDR = 1'b0;
   localparam logic SEL_DATA = 1'b1;

endpackage

// File: rtl/gamlut_regport.sv
module gamlut_regport
   import gamlut_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 12,
   parameter int unsigned EW       = 8,
   parameter int unsigned TOTAL    = 2304,
   parameter int unsigned AINC_BIT = 31
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [DW-1:0] wr_data,
   output logic [AW-1:0] ptr_o,
   output logic          ainc_o,
   output logic          st_en_o,
   output logic [AW-1:0] st_addr_o,
   output logic [EW-1:0] st_data_o
);

   localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);

   logic [AW-1:0] ptr_q;
   logic          ainc_q;
   logic [AW-1:0] ptr_field;
   logic [AW-1:0] ptr_step;
   logic          unused_wr_bits;

   assign ptr_field      = wr_data[AW-1:0];
   assign ptr_step       = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         ainc_q <= 1'b0;
      end else if (wr_en && (wr_sel == SEL_ADDR)) begin
         ptr_q  <= (ptr_field <= LAST) ? ptr_field : '0;
         ainc_q <= wr_data[AINC_BIT];
      end else if (wr_en && (wr_sel == SEL_DATA) && ainc_q) begin
         ptr_q <= ptr_step;
      end
   end

   assign ptr_o     = ptr_q;
   assign ainc_o    = ainc_q;
   assign st_en_o   = wr_en && (wr_sel == SEL_DATA);
   assign st_addr_o = ptr_q;
   assign st_data_o = wr_data[EW-1:0];

endmodule

// File: rtl/gamlut_store.sv
module gamlut_store
   import gamlut_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned EW     = 8,
   parameter int unsigned AW     = 12,
   parameter int unsigned TOTAL  = 2304
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CH-1:0]            gamma_en,
   input  logic                         wr_en,
   input  logic [AW-1:0]                wr_addr,
   input  logic [EW-1:0]                wr_data,
   input  logic [COMP_N-1:0][AW-1:0]    rd_addr,
   output logic [COMP_N-1:0][EW-1:0]    rd_data
);

   logic [EW-1:0]     mem [TOTAL];
   logic [NUM_CH-1:0] en_q;
   logic              wipe;

   // all channels dropped their gamma enable at this edge
   assign wipe = (en_q != '0) && (gamma_en == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         for (int i = 0; i < TOTAL; i++) mem[i] <= '0;
      end else begin
         en_q <= gamma_en;
         if (wipe) begin
            for (int i = 0; i < TOTAL; i++) mem[i] <= '0;
         end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
         end
      end
   end

   for (genvar k = 0; k < COMP_N; k++) begin : g_rd
      assign rd_data[k] = mem[rd_addr[k]];
   end

endmodule

// File: rtl/gamlut_pixel.sv
module gamlut_pixel
   import gamlut_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned CW     = 2,
   parameter int unsigned EW     = 8,
   parameter int unsigned AW     = 12,
   parameter int unsigned SUB    = 256
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH-1:0]          gamma_en,
   input  logic                       pix_valid,
   input  logic [CW-1:0]              pix_ch,
   input  logic [COMP_N*EW-1:0]       pix_rgb,
   output logic [COMP_N-1:0][AW-1:0]  rd_addr,
   input  logic [COMP_N-1:0][EW-1:0]  rd_data,
   output logic                       out_valid,
   output logic [COMP_N*EW-1:0]       out_rgb
);

   localparam logic [AW-1:0] CH_SPAN = AW'(COMP_N * SUB);

   logic                 use_lut;
   logic [AW-1:0]        base;
   logic [COMP_N*EW-1:0] corr;

   always_comb begin
      use_lut = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
         if ((pix_ch == CW'(c)) && gamma_en[c]) use_lut = 1'b1;
      end
   end

   assign base = use_lut ? AW'(pix_ch) * CH_SPAN : '0;

   // component k sits at byte (COMP_N-1-k) of the pixel, red on top
   for (genvar k = 0; k < COMP_N; k++) begin : g_comp
      logic [EW-1:0] comp_in;
      assign comp_in    = pix_rgb[(COMP_N-1-k)*EW +: EW];
      assign rd_addr[k] = base + AW'(k * SUB) + AW'(comp_in);
      assign corr[(COMP_N-1-k)*EW +: EW] = use_lut ? rd_data[k] : comp_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_rgb   <= '0;
      end else begin
         out_valid <= pix_valid;
         if (pix_valid) out_rgb <= corr;
      end
   end

endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank
   import gamlut_pkg::*;
#(
   parameter int unsigned NUM_CH   = 3,
   parameter int unsigned EW       = 8,
   parameter int unsigned DW       = 32,
   parameter int unsigned AINC_BIT = 31,
   parameter int unsigned CW       = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  wr_sel,
   input  logic [DW-1:0]         wr_data,
   input  logic [NUM_CH-1:0]     gamma_en,
   input  logic                  pix_valid,
   input  logic [CW-1:0]         pix_ch,
   input  logic [COMP_N*EW-1:0]  pix_rgb,
   output logic                  out_valid,
   output logic [COMP_N*EW-1:0]  out_rgb
);

   localparam int unsigned SUB   = 1 << EW;
   localparam int unsigned TOTAL = NUM_CH * COMP_N * SUB;
   localparam int unsigned AW    = $clog2(TOTAL);

   initial begin
      if (AINC_BIT < AW || AINC_BIT >= DW)
         $fatal(1, "gamma_lut_bank: autoincrement bit overlaps pointer or is outside the word");
      if ((1 << CW) < NUM_CH)
         $fatal(1, "gamma_lut_bank: channel tag too narrow");
      if (DW < EW)
         $fatal(1, "gamma_lut_bank: write word narrower than an entry");
   end

   logic [AW-1:0]              cur_addr;
   logic                       ainc_q;
   logic                       st_en;
   logic [AW-1:0]              st_addr;
   logic [EW-1:0]              st_data;
   logic [COMP_N-1:0][AW-1:0]  rd_addr;
   logic [COMP_N-1:0][EW-1:0]  rd_data;

   gamlut_regport #(
      .DW(DW), .AW(AW), .EW(EW), .TOTAL(TOTAL), .AINC_BIT(AINC_BIT)
   ) u_regport (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .ptr_o     (cur_addr),
      .ainc_o    (ainc_q),
      .st_en_o   (st_en),
      .st_addr_o (st_addr),
      .st_data_o (st_data)
   );

   gamlut_store #(
      .NUM_CH(NUM_CH), .EW(EW), .AW(AW), .TOTAL(TOTAL)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .gamma_en (gamma_en),
      .wr_en    (st_en),
      .wr_addr  (st_addr),
      .wr_data  (st_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

   gamlut_pixel #(
      .NUM_CH(NUM_CH), .CW(CW), .EW(EW), .AW(AW), .SUB(SUB)
   ) u_pixel (
      .clk       (clk),
      .rst_n     (rst_n),
      .gamma_en  (gamma_en),
      .pix_valid (pix_valid),
      .pix_ch    (pix_ch),
      .pix_rgb   (pix_rgb),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .out_valid (out_valid),
      .out_rgb   (out_rgb)
   );

endmodule

// File: rtl/gamlut_checks.sv
module gamlut_checks
   import gamlut_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned EW     = 8,
   parameter int unsigned CW     = 2,
   parameter int unsigned AW     = 12,
   parameter int unsigned TOTAL  = 2304
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic                  wr_sel,
   input logic [NUM_CH-1:0]     gamma_en,
   input logic                  pix_valid,
   input logic [CW-1:0]         pix_ch,
   input logic [COMP_N*EW-1:0]  pix_rgb,
   input logic                  out_valid,
   input logic [COMP_N*EW-1:0]  out_rgb,
   input logic [AW-1:0]         cur_addr,
   input logic                  ainc_q
);

   localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);

   logic chan_on;
   always_comb begin
      chan_on = 1'b0;
      for (int c = 0; c < NUM_CH; c++)
         if ((pix_ch == CW'(c)) && gamma_en[c]) chan_on = 1'b1;
   end

   logic data_wr;
   assign data_wr = wr_en && (wr_sel == SEL_DATA);

   p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && ainc_q && cur_addr != LAST) |=> cur_addr == $past(cur_addr) + 1'b1);

   p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !ainc_q) |=> $stable(cur_addr));

   p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && ainc_q && cur_addr == LAST) |=> cur_addr == '0);

   p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cur_addr <= LAST);

   p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> out_valid);

   p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !chan_on) |=> out_rgb == $past(pix_rgb));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> (!out_valid && $stable(out_rgb)));

endmodule

bind gamma_lut_bank gamlut_checks #(
   .NUM_CH(NUM_CH), .EW(EW), .CW(CW), .AW(AW), .TOTAL(TOTAL)
) u_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .gamma_en  (gamma_en),
   .pix_valid (pix_valid),
   .pix_ch    (pix_ch),
   .pix_rgb   (pix_rgb),
   .out_valid (out_valid),
   .out_rgb   (out_rgb),
   .cur_addr  (cur_addr),
   .ainc_q    (ainc_q)
);

// File: tb/test_gamma_lut_bank.sv
module test_gamma_lut_bank;

   localparam int TOTAL = 2304;
   localparam int SPAN  = 768;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic [2:0]  gamma_en = '0;
   logic        pix_valid = 1'b0;
   logic [1:0]  pix_ch = '0;
   logic [23:0] pix_rgb = '0;
   logic        out_valid;
   logic [23:0] out_rgb;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [7:0] mref [TOTAL];
   int         m_ptr = 0;
   bit         m_ainc = 0;
   logic [2:0] g_model = '0;

   always #2 clk = ~clk;

   gamma_lut_bank i_gamma_lut_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .gamma_en(gamma_en), .pix_valid(pix_valid),
      .pix_ch(pix_ch), .pix_rgb(pix_rgb), .out_valid(out_valid),
      .out_rgb(out_rgb)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_pix(int ch, logic [23:0] rgb);
      logic [23:0] r;
      r = rgb;
      if (ch < 3 && g_model[ch]) begin
         for (int k = 0; k < 3; k++)
            r[(2-k)*8 +: 8] = mref[ch*SPAN + k*256 + int'(rgb[(2-k)*8 +: 8])];
      end
      return r;
   endfunction

   task automatic wr_ptr(int a, bit inc);
      wr_en = 1; wr_sel = 0;
      wr_data = {inc, 19'd0, 12'(a)};
      @(negedge clk);
      wr_en = 0;
      m_ptr = (a < TOTAL) ? a : 0;
      m_ainc = inc;
   endtask

   task automatic wr_val(logic [7:0] v);
      wr_en = 1; wr_sel = 1;
      wr_data = {$urandom(), v} >> 0;
      wr_data[7:0] = v;
      @(negedge clk);
      wr_en = 0;
      mref[m_ptr] = v;
      if (m_ainc) m_ptr = (m_ptr == TOTAL-1) ? 0 : m_ptr + 1;
   endtask

   task automatic set_gamma(logic [2:0] v);
      gamma_en = v;
      @(negedge clk);
      if (g_model != 0 && v == 0)
         for (int i = 0; i < TOTAL; i++) mref[i] = 8'd0;
      g_model = v;
   endtask

   task automatic send(int ch, logic [23:0] rgb, string req);
      logic [23:0] e;
      pix_valid = 1; pix_ch = 2'(ch); pix_rgb = rgb;
      e = exp_pix(ch, rgb);
      @(negedge clk);
      pix_valid = 0;
      chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
      chk({req, " pixel"}, {8'd0, out_rgb}, {8'd0, e});
   endtask

   task automatic load_chan(int ch);
      wr_ptr(ch*SPAN, 1);
      for (int i = 0; i < SPAN; i++) wr_val(8'($urandom()));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < TOTAL; i++) mref[i] = 8'd0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
      chk("R1 out_rgb", {8'd0, out_rgb}, 32'd0);

      // R8: all channels bypassed
      for (int i = 0; i < 20; i++) send($urandom_range(0, 3), 24'($urandom()), "R8 bypass");

      // R1/R4: pointer starts at 0 with autoincrement off
      set_gamma(3'b001);
      send(0, 24'h000000, "R1 zero table");
      wr_val(8'h5A);
      wr_val(8'h77);
      send(0, 24'h000000, "R4 overwrite entry 0");
      send(0, 24'h010101, "R4 entry 1 untouched");

      // R2/R3/R7: full load then random lookups
      set_gamma(3'b111);
      for (int c = 0; c < 3; c++) load_chan(c);
      for (int i = 0; i < 200; i++) send($urandom_range(0, 2), 24'($urandom()), "R7 lookup");
      send(1, 24'hFF00FF, "R2 sub-table edges");
      send(2, 24'h00FF80, "R2 last channel");

      // R10: idle cycles keep output
      @(negedge clk);
      chk("R10 idle valid", {31'd0, out_valid}, 32'd0);
      chk("R10 idle hold", {8'd0, out_rgb}, {8'd0, exp_pix(2, 24'h00FF80)});

      // R4: hold in middle of memory
      wr_ptr(SPAN + 300, 0);
      wr_val(8'h11); wr_val(8'h22); wr_val(8'h33);
      send(1, 24'h2C2C2C, "R4 hold mid");
      send(1, 24'h2D2D2D, "R4 neighbour");

      // R5: wrap from last entry
      wr_ptr(TOTAL - 1, 1);
      wr_val(8'hA5); wr_val(8'h3C);
      send(2, 24'h0000FF, "R5 last entry");
      send(0, 24'h000000, "R5 wrapped to 0");

      // R6: out-of-range pointer
      wr_ptr(4000, 1);
      wr_val(8'hC3);
      send(0, 24'h000000, "R6 range to 0");
      wr_ptr(SPAN*2 + 512 + 7, 1);
      wr_val(8'h9E);
      send(2, 24'h000007, "R6 exact pointer");

      // R8: mixed enables and channel 3
      set_gamma(3'b010);
      for (int i = 0; i < 60; i++) send($urandom_range(0, 3), 24'($urandom()), "R8 mixed");
      send(3, 24'h123456, "R8 channel 3");

      // R9: all off wipes, write at that edge dropped
      wr_ptr(5, 0);
      gamma_en = 3'b000;
      wr_en = 1; wr_sel = 1; wr_data = 32'h000000EE;
      @(negedge clk);
      wr_en = 0;
      for (int i = 0; i < TOTAL; i++) mref[i] = 8'd0;
      g_model = 3'b000;
      set_gamma(3'b111);
      for (int i = 0; i < 30; i++) send($urandom_range(0, 2), 24'($urandom()), "R9 wiped");
      send(0, 24'h050505, "R9 write at wipe dropped");

      // reload after wipe
      load_chan(1);
      for (int i = 0; i < 30; i++) send(1, 24'($urandom()), "R3 reload");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule